// File: doc/BRIEF.md
# Video Core Control Register Bank

This block is the software-facing control store for a streaming video processing core. A host reaches it through a simple single-cycle request port (valid, write flag, byte address, write data). It answers every read with a registered response one cycle later. The bank holds the enable, update-permit and clear-status controls, sticky event and error flags with a masked interrupt, a fixed version word, three read-only debug words, and the configuration the core runs with: the active frame size and a 2-bit colour-pattern phase.

Configuration is double-buffered. Host writes land in a shadow copy, which is what reads return. The shadow copy is moved to the active copy, which drives the core, on the rising edge of vertical blanking, but only while both enable and update-permit are set. Two software resets are provided. The held reset returns the configuration to its defaults at once and keeps the core in reset until software removes it. The frame-aligned reset waits for the next rising edge of start of frame, performs the same reset, pulses the core reset for one cycle and then clears its own request bit.

The request port applies no back-pressure: a request is accepted in the cycle it is valid, and there is no ready signal. Vertical blanking, start of frame and the event inputs are synchronous to `clk`.

Top module: `vcrb_top`

## Requirements
- R1: After reset the control word reads 0, the status and error words read 0, `irq` and `core_rst` are 0, and the active outputs hold the defaults (horizontal 1920, vertical 1080, phase 0).
- R2: A read request returns `rd_valid`=1 with data in the next cycle. Word offsets are: 0x000 control, 0x004 status, 0x008 error, 0x00C interrupt mask, 0x010 version, 0x014/0x018/0x01C debug words 0..2 (`dbg_in` bits 31:0, 63:32, 95:64), 0x020 frame size (vertical in bits 31:16, horizontal in bits 15:0), 0x100 phase (bits 1:0). Any other offset, and any offset with address bits 1:0 not zero, reads 0.
- R3: Writes to the status, version and debug offsets are ignored.
- R4: Writes to frame size and phase change only the shadow copy, which is what reads return. The active outputs do not change on a write.
- R5: On a rising edge of `vblank_in`, when control bit 0 (enable) and bit 1 (update permit) are both 1, the active outputs take the shadow values in the cycle after the edge. A level held high does not commit again.
- R6: A rising edge of `vblank_in` with enable or update permit at 0 leaves the active outputs unchanged.
- R7: Status bits are set by `stat_evt` and error bits by `err_evt`, and they stay set until they are cleared.
- R8: Status and error clear while control bit 2 (clear) and enable are both 1. Clear with enable at 0 has no effect.
- R9: `irq` is 1 exactly when some status bit and the same bit of the interrupt mask are both 1.
- R10: While control bit 31 is 1, `core_rst` is 1, `core_en` is 0, and shadow and active configuration sit at their defaults (configuration writes are ignored). Status and error are held at 0. Writing bit 31 back to 0 releases the reset.
- R11: With control bit 30 set, nothing happens until the next rising edge of `sof_in`. After that edge the shadow and active configuration, status and error return to their defaults, `core_rst` is 1 for one cycle, and bit 30 reads 0.
- R12: Only control bits 0, 1, 2, 30 and 31 are stored; every other control bit reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Request valid |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (12) | Byte address |
| bus_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read response valid |
| rd_data | output | 32 | Read response data |
| vblank_in | input | 1 | Vertical blanking level |
| sof_in | input | 1 | Start of frame level |
| stat_evt | input | STAT_W (4) | Status event set pulses |
| err_evt | input | ERR_W (4) | Error event set pulses |
| dbg_in | input | 96 | Three debug words |
| core_en | output | 1 | Core enable, forced low in reset |
| core_rst | output | 1 | Core reset |
| act_hsize | output | H_W (16) | Active horizontal size |
| act_vsize | output | V_W (16) | Active vertical size |
| act_phase | output | PH_W (2) | Active pattern phase |
| irq | output | 1 | Masked interrupt |

## Verification
The bound assertions check on every cycle:
- the read response timing;
- that the active configuration moves only at a qualified blanking edge, a held reset or a frame-aligned reset;
- that a qualified edge copies exactly the shadow values;
- that each blanking rise gives a single event;
- that the held reset keeps defaults;
- that the frame-aligned reset clears its own request;
- that an asserted interrupt persists until something entitled to drop it occurs.

The address map contents, the ignored writes to read-only words, and the storage of only the defined control bits are shown only by the bench's directed scenarios. The same holds for the gating of clear-status by enable, for a held blanking level not committing twice, and for the full release sequences of both resets.

// File: rtl/vcrb_pkg.sv
package vcrb_pkg;
  // word indices (byte offset / 4)
  localparam int unsigned IDX_CTL   = 0;
  localparam int unsigned IDX_STAT  = 1;
  localparam int unsigned IDX_ERR   = 2;
  localparam int unsigned IDX_MASK  = 3;
  localparam int unsigned IDX_VER   = 4;
  localparam int unsigned IDX_DBG0  = 5;
  localparam int unsigned IDX_SIZE  = 8;
  localparam int unsigned IDX_PHASE = 64;
  localparam int unsigned DBG_N     = 3;
  // control bit positions
  localparam int unsigned CB_EN   = 0;
  localparam int unsigned CB_UPD  = 1;
  localparam int unsigned CB_CLR  = 2;
  localparam int unsigned CB_AUTO = 30;
  localparam int unsigned CB_HOLD = 31;
  localparam int unsigned VPOS    = 16;
endpackage

// File: rtl/vcrb_edge.sv
module vcrb_edge #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] rise
);
  logic [N-1:0] prev_q;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n) prev_q[i] <= 1'b0;
      else        prev_q[i] <= lvl[i];
    end
    assign rise[i] = lvl[i] & ~prev_q[i];
  end
endmodule

// File: rtl/vcrb_dbuf.sv
module vcrb_dbuf #(
  parameter int unsigned W   = 16,
  parameter logic [W-1:0] DEF = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hold_rst,
  input  logic         frame_rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         commit,
  output logic [W-1:0] shadow_q,
  output logic [W-1:0] active_q
);
  always_ff @(posedge clk) begin
    if (!rst_n || hold_rst || frame_rst) begin
      shadow_q <= DEF;
      active_q <= DEF;
    end else begin
      if (wr_en)  shadow_q <= wr_data;
      if (commit) active_q <= shadow_q;
    end
  end
endmodule

// File: rtl/vcrb_sticky.sv
module vcrb_sticky #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic [W-1:0] set,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n || clr) q <= '0;
    else               q <= q | set;
  end
endmodule

// File: rtl/vcrb_top.sv
module vcrb_top
  import vcrb_pkg::*;
#(
  parameter int unsigned ADDR_W  = 12,
  parameter int unsigned STAT_W  = 4,
  parameter int unsigned ERR_W   = 4,
  parameter int unsigned H_W     = 16,
  parameter int unsigned V_W     = 16,
  parameter int unsigned PH_W    = 2,
  parameter logic [H_W-1:0]  DEF_H  = 16'd1920,
  parameter logic [V_W-1:0]  DEF_V  = 16'd1080,
  parameter logic [PH_W-1:0] DEF_PH = '0,
  parameter logic [31:0]     VERSION = 32'h0105_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic              rd_valid,
  output logic [31:0]       rd_data,
  input  logic              vblank_in,
  input  logic              sof_in,
  input  logic [STAT_W-1:0] stat_evt,
  input  logic [ERR_W-1:0]  err_evt,
  input  logic [DBG_N*32-1:0] dbg_in,
  output logic              core_en,
  output logic              core_rst,
  output logic [H_W-1:0]    act_hsize,
  output logic [V_W-1:0]    act_vsize,
  output logic [PH_W-1:0]   act_phase,
  output logic              irq
);
  localparam int unsigned WIDX_W = ADDR_W - 2;

  logic [WIDX_W-1:0] widx;
  logic aligned, wr, rd;
  logic ctl_wr, mask_wr, size_wr, phase_wr;
  logic ctl_en_q, ctl_upd_q, ctl_clr_q, ctl_auto_q, ctl_hold_q, auto_pulse_q;
  logic vb_evt, sof_evt, auto_fire, commit, flag_clr;
  logic [STAT_W-1:0] stat_q, mask_q;
  logic [ERR_W-1:0]  err_q;
  logic [H_W-1:0]    sh_h;
  logic [V_W-1:0]    sh_v;
  logic [PH_W-1:0]   sh_ph;
  logic [31:0]       rd_mux;
  logic [1:0]        edges;

  assign widx    = bus_addr[ADDR_W-1:2];
  assign aligned = (bus_addr[1:0] == 2'b00);
  assign wr      = bus_valid & bus_wr & aligned;
  assign rd      = bus_valid & ~bus_wr;

  assign ctl_wr   = wr && (widx == WIDX_W'(IDX_CTL));
  assign mask_wr  = wr && (widx == WIDX_W'(IDX_MASK));
  assign size_wr  = wr && (widx == WIDX_W'(IDX_SIZE))  && !ctl_hold_q;
  assign phase_wr = wr && (widx == WIDX_W'(IDX_PHASE)) && !ctl_hold_q;

  // frame-boundary edge events
  vcrb_edge #(.N(2)) u_edge (
    .clk(clk), .rst_n(rst_n),
    .lvl({sof_in, vblank_in}),
    .rise(edges)
  );
  assign vb_evt  = edges[0];
  assign sof_evt = edges[1];

  assign auto_fire = sof_evt & ctl_auto_q;
  assign commit    = vb_evt & ctl_en_q & ctl_upd_q;
  assign flag_clr  = (ctl_en_q & ctl_clr_q) | ctl_hold_q | auto_fire;

  // control word
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_en_q     <= 1'b0;
      ctl_upd_q    <= 1'b0;
      ctl_clr_q    <= 1'b0;
      ctl_auto_q   <= 1'b0;
      ctl_hold_q   <= 1'b0;
      auto_pulse_q <= 1'b0;
    end else begin
      auto_pulse_q <= auto_fire;
      if (auto_fire) ctl_auto_q <= 1'b0;
      if (ctl_wr) begin
        ctl_en_q   <= bus_wdata[CB_EN];
        ctl_upd_q  <= bus_wdata[CB_UPD];
        ctl_clr_q  <= bus_wdata[CB_CLR];
        ctl_auto_q <= bus_wdata[CB_AUTO];
        ctl_hold_q <= bus_wdata[CB_HOLD];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_wr) mask_q <= bus_wdata[STAT_W-1:0];
  end

  // sticky flags
  vcrb_sticky #(.W(STAT_W)) u_stat (
    .clk(clk), .rst_n(rst_n), .clr(flag_clr), .set(stat_evt), .q(stat_q)
  );
  vcrb_sticky #(.W(ERR_W)) u_err (
    .clk(clk), .rst_n(rst_n), .clr(flag_clr), .set(err_evt), .q(err_q)
  );

  // double-buffered configuration
  vcrb_dbuf #(.W(H_W), .DEF(DEF_H)) u_hsize (
    .clk(clk), .rst_n(rst_n), .hold_rst(ctl_hold_q), .frame_rst(auto_fire),
    .wr_en(size_wr), .wr_data(bus_wdata[H_W-1:0]), .commit(commit),
    .shadow_q(sh_h), .active_q(act_hsize)
  );
  vcrb_dbuf #(.W(V_W), .DEF(DEF_V)) u_vsize (
    .clk(clk), .rst_n(rst_n), .hold_rst(ctl_hold_q), .frame_rst(auto_fire),
    .wr_en(size_wr), .wr_data(bus_wdata[VPOS+V_W-1:VPOS]), .commit(commit),
    .shadow_q(sh_v), .active_q(act_vsize)
  );
  vcrb_dbuf #(.W(PH_W), .DEF(DEF_PH)) u_phase (
    .clk(clk), .rst_n(rst_n), .hold_rst(ctl_hold_q), .frame_rst(auto_fire),
    .wr_en(phase_wr), .wr_data(bus_wdata[PH_W-1:0]), .commit(commit),
    .shadow_q(sh_ph), .active_q(act_phase)
  );

  // read decode
  always_comb begin
    rd_mux = '0;
    if (aligned) begin
      if (widx == WIDX_W'(IDX_CTL)) begin
        rd_mux[CB_EN]   = ctl_en_q;
        rd_mux[CB_UPD]  = ctl_upd_q;
        rd_mux[CB_CLR]  = ctl_clr_q;
        rd_mux[CB_AUTO] = ctl_auto_q;
        rd_mux[CB_HOLD] = ctl_hold_q;
      end
      if (widx == WIDX_W'(IDX_STAT))  rd_mux[STAT_W-1:0] = stat_q;
      if (widx == WIDX_W'(IDX_ERR))   rd_mux[ERR_W-1:0]  = err_q;
      if (widx == WIDX_W'(IDX_MASK))  rd_mux[STAT_W-1:0] = mask_q;
      if (widx == WIDX_W'(IDX_VER))   rd_mux = VERSION;
      for (int i = 0; i < DBG_N; i++) begin
        if (widx == WIDX_W'(IDX_DBG0 + i)) rd_mux = dbg_in[i*32 +: 32];
      end
      if (widx == WIDX_W'(IDX_SIZE)) begin
        rd_mux[H_W-1:0]           = sh_h;
        rd_mux[VPOS+V_W-1:VPOS]   = sh_v;
      end
      if (widx == WIDX_W'(IDX_PHASE)) rd_mux[PH_W-1:0] = sh_ph;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd;
      rd_data  <= rd ? rd_mux : 32'h0;
    end
  end

  assign core_rst = ctl_hold_q | auto_pulse_q;
  assign core_en  = ctl_en_q & ~core_rst;
  assign irq      = |(stat_q & mask_q);
endmodule

// File: rtl/vcrb_chk.sv
module vcrb_chk #(
  parameter int unsigned H_W  = 16,
  parameter int unsigned V_W  = 16,
  parameter int unsigned PH_W = 2,
  parameter logic [H_W-1:0]  DEF_H  = '0,
  parameter logic [V_W-1:0]  DEF_V  = '0,
  parameter logic [PH_W-1:0] DEF_PH = '0
) (
  input logic clk,
  input logic rst_n,
  input logic bus_valid,
  input logic bus_wr,
  input logic rd_valid,
  input logic vb_evt,
  input logic sof_evt,
  input logic ctl_en_q,
  input logic ctl_upd_q,
  input logic ctl_clr_q,
  input logic ctl_auto_q,
  input logic ctl_hold_q,
  input logic ctl_wr,
  input logic mask_wr,
  input logic core_rst,
  input logic irq,
  input logic [H_W-1:0]  act_h,
  input logic [V_W-1:0]  act_v,
  input logic [PH_W-1:0] act_ph,
  input logic [H_W-1:0]  sh_h,
  input logic [V_W-1:0]  sh_v,
  input logic [PH_W-1:0] sh_ph
);
  logic [H_W+V_W+PH_W-1:0] act_all, sh_all, def_all;
  assign act_all = {act_h, act_v, act_ph};
  assign sh_all  = {sh_h, sh_v, sh_ph};
  assign def_all = {DEF_H, DEF_V, DEF_PH};

  p_rd_resp_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_wr) |=> rd_valid);
  p_no_rd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_valid && !bus_wr) |=> !rd_valid);
  p_hold_cfg_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!vb_evt && !sof_evt && !ctl_hold_q) |=> $stable(act_all));
  p_no_commit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (vb_evt && !(ctl_en_q && ctl_upd_q) && !ctl_hold_q && !(sof_evt && ctl_auto_q))
      |=> $stable(act_all));
  p_commit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (vb_evt && ctl_en_q && ctl_upd_q && !ctl_hold_q && !(sof_evt && ctl_auto_q))
      |=> (act_all == $past(sh_all)));
  p_one_event_r5: assert property (@(posedge clk) disable iff (!rst_n)
    vb_evt |=> !vb_evt);
  p_hold_rst_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_hold_q |=> (act_all == def_all && sh_all == def_all));
  p_auto_rst_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (sof_evt && ctl_auto_q && !ctl_wr) |=> (!ctl_auto_q && core_rst && act_all == def_all));
  p_irq_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !(ctl_en_q && ctl_clr_q) && !ctl_hold_q && !(sof_evt && ctl_auto_q) && !mask_wr)
      |=> irq);
endmodule

bind vcrb_top vcrb_chk #(
  .H_W(H_W), .V_W(V_W), .PH_W(PH_W),
  .DEF_H(DEF_H), .DEF_V(DEF_V), .DEF_PH(DEF_PH)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_wr(bus_wr),
  .rd_valid(rd_valid), .vb_evt(vb_evt), .sof_evt(sof_evt),
  .ctl_en_q(ctl_en_q), .ctl_upd_q(ctl_upd_q), .ctl_clr_q(ctl_clr_q),
  .ctl_auto_q(ctl_auto_q), .ctl_hold_q(ctl_hold_q), .ctl_wr(ctl_wr),
  .mask_wr(mask_wr), .core_rst(core_rst), .irq(irq),
  .act_h(act_hsize), .act_v(act_vsize), .act_ph(act_phase),
  .sh_h(sh_h), .sh_v(sh_v), .sh_ph(sh_ph)
);

// File: tb/vcrb_top_tb.sv
module vcrb_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0, bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        rd_valid;
  logic [31:0] rd_data;
  logic        vblank_in = 1'b0, sof_in = 1'b0;
  logic [3:0]  stat_evt = '0, err_evt = '0;
  logic [95:0] dbg_in = {32'hC0DE_0002, 32'hC0DE_0001, 32'hC0DE_0000};
  logic        core_en, core_rst, irq;
  logic [15:0] act_hsize, act_vsize;
  logic [1:0]  act_phase;

  int total = 0, bad = 0;
  logic done = 1'b0;

  localparam logic [31:0] VER = 32'h0105_0000;

  vcrb_top u_dut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rd_valid(rd_valid),
    .rd_data(rd_data), .vblank_in(vblank_in), .sof_in(sof_in),
    .stat_evt(stat_evt), .err_evt(err_evt), .dbg_in(dbg_in),
    .core_en(core_en), .core_rst(core_rst), .act_hsize(act_hsize),
    .act_vsize(act_vsize), .act_phase(act_phase), .irq(irq)
  );

  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr32(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_valid = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd32(input logic [11:0] a, output logic [31:0] d, output logic v);
    @(negedge clk);
    bus_valid = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(posedge clk);
    @(negedge clk);
    bus_valid = 1'b0;
    d = rd_data; v = rd_valid;
  endtask

  task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] d; logic v;
    rd32(a, d, v);
    chk({req, " rd_valid"}, {31'b0, v}, 32'd1);
    chk(req, d, exp);
  endtask

  task automatic pulse_vb();
    @(negedge clk); vblank_in = 1'b1;
    @(negedge clk); vblank_in = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk_act(input string req, input logic [15:0] h, input logic [15:0] v, input logic [1:0] p);
    chk({req, " hsize"}, {16'b0, act_hsize}, {16'b0, h});
    chk({req, " vsize"}, {16'b0, act_vsize}, {16'b0, v});
    chk({req, " phase"}, {30'b0, act_phase}, {30'b0, p});
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk_act("R1 reset", 16'd1920, 16'd1080, 2'd0);
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 core_rst", {31'b0, core_rst}, 0);
    rd_chk("R1 ctl", 12'h000, 32'h0);
    rd_chk("R1 status", 12'h004, 32'h0);
    rd_chk("R1 error", 12'h008, 32'h0);
  endtask

  task automatic t_map();
    rd_chk("R2 version", 12'h010, VER);
    rd_chk("R2 dbg0", 12'h014, 32'hC0DE_0000);
    rd_chk("R2 dbg2", 12'h01C, 32'hC0DE_0002);
    rd_chk("R2 size default", 12'h020, 32'h0438_0780);
    rd_chk("R2 unmapped 0x0FC", 12'h0FC, 32'h0);
    rd_chk("R2 misaligned", 12'h011, 32'h0);
  endtask

  task automatic t_readonly();
    wr32(12'h010, 32'hDEAD_BEEF);
    rd_chk("R3 version kept", 12'h010, VER);
    wr32(12'h018, 32'h1234_5678);
    rd_chk("R3 dbg1 kept", 12'h018, 32'hC0DE_0001);
    wr32(12'h004, 32'hF);
    rd_chk("R3 status kept", 12'h004, 32'h0);
  endtask

  task automatic t_ctl_bits();
    wr32(12'h000, 32'h3FFF_FFF8);
    rd_chk("R12 undefined bits", 12'h000, 32'h0);
    wr32(12'h000, 32'h0000_0007);
    rd_chk("R12 low bits", 12'h000, 32'h7);
    wr32(12'h000, 32'h0);
  endtask

  task automatic t_shadow();
    wr32(12'h000, 32'h1);
    wr32(12'h020, 32'h0258_0320);
    wr32(12'h100, 32'h3);
    rd_chk("R4 size shadow", 12'h020, 32'h0258_0320);
    rd_chk("R4 phase shadow", 12'h100, 32'h3);
    chk_act("R4 active unchanged", 16'd1920, 16'd1080, 2'd0);
  endtask

  task automatic t_no_update();
    pulse_vb();
    chk_act("R6 upd=0", 16'd1920, 16'd1080, 2'd0);
    wr32(12'h000, 32'h2);
    pulse_vb();
    chk_act("R6 en=0", 16'd1920, 16'd1080, 2'd0);
  endtask

  task automatic t_commit();
    wr32(12'h000, 32'h3);
    pulse_vb();
    chk_act("R5 commit", 16'd800, 16'd600, 2'd3);
    wr32(12'h020, 32'h0100_0200);
    chk_act("R4 after write", 16'd800, 16'd600, 2'd3);
    @(negedge clk); vblank_in = 1'b1;
    @(negedge clk);
    chk_act("R5 second commit", 16'd512, 16'd256, 2'd3);
    wr32(12'h020, 32'h0040_0080);
    idle(3);
    chk_act("R5 held level", 16'd512, 16'd256, 2'd3);
    vblank_in = 1'b0;
    pulse_vb();
    chk_act("R5 next edge", 16'd128, 16'd64, 2'd3);
  endtask

  task automatic t_status();
    @(negedge clk); stat_evt = 4'b0010;
    @(negedge clk); stat_evt = 4'b0000;
    rd_chk("R7 status set", 12'h004, 32'h2);
    idle(5);
    rd_chk("R7 status sticky", 12'h004, 32'h2);
    chk("R9 irq masked", {31'b0, irq}, 0);
    wr32(12'h00C, 32'h2);
    chk("R9 irq on", {31'b0, irq}, 1);
    wr32(12'h00C, 32'h1);
    chk("R9 irq other bit", {31'b0, irq}, 0);
    wr32(12'h00C, 32'h2);
    wr32(12'h000, 32'h4);
    rd_chk("R8 clear without enable", 12'h004, 32'h2);
    wr32(12'h000, 32'h5);
    rd_chk("R8 clear with enable", 12'h004, 32'h0);
    chk("R9 irq off", {31'b0, irq}, 0);
    wr32(12'h000, 32'h1);
    @(negedge clk); err_evt = 4'b1001;
    @(negedge clk); err_evt = 4'b0000;
    rd_chk("R7 error set", 12'h008, 32'h9);
    wr32(12'h000, 32'h5);
    rd_chk("R8 error clear", 12'h008, 32'h0);
    wr32(12'h000, 32'h3);
  endtask

  task automatic t_hold_reset();
    wr32(12'h000, 32'h8000_0000);
    chk("R10 core_rst", {31'b0, core_rst}, 1);
    chk("R10 core_en", {31'b0, core_en}, 0);
    @(negedge clk);
    chk_act("R10 defaults", 16'd1920, 16'd1080, 2'd0);
    wr32(12'h020, 32'h0011_0022);
    rd_chk("R10 write ignored", 12'h020, 32'h0438_0780);
    @(negedge clk); stat_evt = 4'b0001;
    @(negedge clk); stat_evt = 4'b0000;
    rd_chk("R10 status held", 12'h004, 32'h0);
    wr32(12'h000, 32'h0);
    chk("R10 released", {31'b0, core_rst}, 0);
    chk_act("R10 after release", 16'd1920, 16'd1080, 2'd0);
  endtask

  task automatic t_auto_reset();
    wr32(12'h000, 32'h3);
    wr32(12'h020, 32'h0258_0320);
    wr32(12'h100, 32'h2);
    pulse_vb();
    chk_act("R11 setup", 16'd800, 16'd600, 2'd2);
    wr32(12'h000, 32'h4000_0003);
    idle(3);
    chk_act("R11 waits for frame", 16'd800, 16'd600, 2'd2);
    chk("R11 no early reset", {31'b0, core_rst}, 0);
    rd_chk("R11 request visible", 12'h000, 32'h4000_0003);
    @(negedge clk); sof_in = 1'b1;
    @(negedge clk); sof_in = 1'b0;
    chk_act("R11 reset at frame", 16'd1920, 16'd1080, 2'd0);
    chk("R11 pulse", {31'b0, core_rst}, 1);
    @(negedge clk);
    chk("R11 pulse ends", {31'b0, core_rst}, 0);
    rd_chk("R11 self clear", 12'h000, 32'h3);
    rd_chk("R11 shadow default", 12'h100, 32'h0);
  endtask

  initial begin
    for (int i = 0; i < 20000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    t_reset();
    t_map();
    t_readonly();
    t_ctl_bits();
    t_shadow();
    t_no_update();
    t_commit();
    t_status();
    t_hold_reset();
    t_auto_reset();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule